// File: doc/BRIEF.md
# Banked GPIO Controller with Masked Half-Word Writes

This block is a register-mapped general-purpose I/O controller built from a parameterised number of pin banks, each up to 32 pins wide. Software reaches every bank through a simple single-cycle register bus. A write takes effect at the clock edge where it is presented. A read returns combinational data from the register addressed in the same cycle.

For each pin there is an output value, a direction bit and an output-enable bit. A pin drives only when both its direction bit and its enable bit are set. An input register reports each pin level after a two-flop synchroniser. Two half-word output registers carry a per-bit write-protect mask in their upper half, so that software can change chosen output bits without a read-modify-write.

Each pin has its own interrupt logic. Type, polarity and any-edge selects set how the pin is detected. The per-pin mask is changed only through separate unmask and mask strobe registers. A status register latches edge events and tracks levels. One interrupt output combines the unmasked status of all banks.

Top module: `gpio_banked`

## Requirements
- R1: After reset every output value, direction, output-enable, type, polarity and any-edge bit is 0, every pin is masked (mask status reads all ones), `pin_oe` is 0 and `irq` is 0.
- R2: A write to offset 0 (lower half) or offset 1 (upper half) takes a mask from bits 31:16 and data from bits 15:0. For each bit, a mask of 0 loads the data bit into the output register and a mask of 1 keeps the old value. The change is visible from the next cycle.
- R3: A read of offset 0 or 1 returns only that half of the output register in bits 15:0, with bits 31:16 reading 0.
- R4: Offset 2 holds the full output value. Reads return it and `pin_out` drives it, and a write replaces all bits.
- R5: `pin_oe` for a pin is 1 only when both its direction bit (offset 4) and its output-enable bit (offset 5) are 1. `pin_oe` changes only in the cycle after a register write.
- R6: Offset 3 reports the pin levels. A change before clock edge k is readable after edge k+1. Writes to offset 3 have no effect.
- R7: Writing ones to offset 7 clears those mask bits (unmasks the pins). Writing ones to offset 8 sets those mask bits. Zero bits in either write leave the mask unchanged, and offset 6 reads the mask.
- R8: A pin with type bit 1 (offset 10) is edge detected. Polarity bit 1 (offset 11) selects a rising edge and 0 a falling edge. Any-edge bit 1 (offset 12) selects both edges. For a pin change before edge k, the status bit (offset 9) is set after edge k+2.
- R9: Edge status bits are sticky until a 1 is written to them at offset 9. Writing 0 leaves them unchanged, and a new event in the same cycle as the clear wins.
- R10: A pin with type bit 0 is level detected. Its status bit equals the synchronised level when polarity is 1, and its inverse when polarity is 0, with the R8 latency. Writes to offset 9 do not change level status bits.
- R11: `irq` is 1 exactly when some bank has a status bit set whose mask bit is 0.
- R12: Register address bits above the low four select the bank, and a write to one bank leaves every other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W (5) | Word address: bank in the upper bits, register offset in bits 3:0 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the register at `bus_addr`, same cycle |
| pin_in | input | NUM_BANKS*PIN_W | Pin levels, bank b in bits b*PIN_W upward |
| pin_out | output | NUM_BANKS*PIN_W | Output values |
| pin_oe | output | NUM_BANKS*PIN_W | Per-pin drive enable |
| irq | output | 1 | Combined interrupt request |

## Verification
Register writes are due in the cycle after the write edge, and read data in the same cycle as the address. Pin levels are due in the input register two edges after they change, and in status and `irq` three edges after. Each check is issued one step after a clock edge, and the scoreboard compares it on the following falling edge, so every comparison lands in a known cycle relative to the stimulus. For the pin tests the bench checks both the last cycle that must still show the old value and the first cycle that must show the new one. This confirms the exact synchroniser depth and not just the eventual result.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   localparam int BUS_W     = 32;
   localparam int OFS_W     = 4;
   localparam int MASK_LSB  = 16;

   typedef enum logic [OFS_W-1:0] {
      OFS_OUT_LO  = 4'd0,
      OFS_OUT_HI  = 4'd1,
      OFS_OUT     = 4'd2,
      OFS_IN      = 4'd3,
      OFS_DIR     = 4'd4,
      OFS_OE      = 4'd5,
      OFS_IMASK   = 4'd6,
      OFS_IUNMASK = 4'd7,
      OFS_IMASKON = 4'd8,
      OFS_ISTAT   = 4'd9,
      OFS_ITYPE   = 4'd10,
      OFS_IPOL    = 4'd11,
      OFS_IANY    = 4'd12
   } reg_ofs_e;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync2: STAGES must be at least 2");
   end

   logic [W-1:0] stage_q [STAGES];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
      end else begin
         stage_q[0] <= d;
         for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] lvl,
   input  logic [W-1:0] itype,
   input  logic [W-1:0] ipol,
   input  logic [W-1:0] iany,
   input  logic [W-1:0] clr,
   output logic [W-1:0] stat
);
   logic [W-1:0] prev_q;
   logic [W-1:0] rise, fall, edge_hit, lvl_hit, stat_d;

   always_comb begin
      rise     = lvl & ~prev_q;
      fall     = ~lvl & prev_q;
      edge_hit = (iany & (rise | fall)) | (~iany & ((ipol & rise) | (~ipol & fall)));
      lvl_hit  = (ipol & lvl) | (~ipol & ~lvl);
      stat_d   = (itype & ((stat & ~clr) | edge_hit)) | (~itype & lvl_hit);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_q <= '0;
         stat   <= '0;
      end else begin
         prev_q <= lvl;
         stat   <= stat_d;
      end
   end

   // R9: an edge-type status bit never drops unless a 1 was written to it
   p_edge_sticky_r9: assert property (@(posedge clk) disable iff (rst)
      ((($past(stat) & $past(itype) & ~$past(clr)) & ~stat) == '0));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
   import gpio_pkg::*;
#(
   parameter int PIN_W       = 32,
   parameter int SYNC_STAGES = 2,
   localparam int HALF       = PIN_W / 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  reg_ofs_e         ofs,
   input  logic [BUS_W-1:0] wdata,
   output logic [BUS_W-1:0] rdata,
   input  logic [PIN_W-1:0] pin_i,
   output logic [PIN_W-1:0] pin_o,
   output logic [PIN_W-1:0] pin_oe,
   output logic             irq_o
);
   logic [PIN_W-1:0] out_q, dir_q, oe_q, mask_q, type_q, pol_q, any_q;
   logic [PIN_W-1:0] lvl, stat, clr, wr_bits;
   logic [HALF-1:0]  wr_mask, wr_half;

   assign wr_bits = wdata[PIN_W-1:0];
   assign wr_mask = wdata[MASK_LSB +: HALF];
   assign wr_half = wdata[HALF-1:0];

   gpio_sync2 #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .d(pin_i), .q(lvl)
   );

   assign clr = (wr_en && ofs == OFS_ISTAT) ? wr_bits : '0;

   gpio_irq_detect #(.W(PIN_W)) u_det (
      .clk(clk), .rst(rst), .lvl(lvl), .itype(type_q), .ipol(pol_q),
      .iany(any_q), .clr(clr), .stat(stat)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_q  <= '0;
         dir_q  <= '0;
         oe_q   <= '0;
         mask_q <= '1;
         type_q <= '0;
         pol_q  <= '0;
         any_q  <= '0;
      end else if (wr_en) begin
         unique case (ofs)
            OFS_OUT_LO:  out_q[HALF-1:0]     <= (out_q[HALF-1:0] & wr_mask) | (wr_half & ~wr_mask);
            OFS_OUT_HI:  out_q[PIN_W-1:HALF] <= (out_q[PIN_W-1:HALF] & wr_mask) | (wr_half & ~wr_mask);
            OFS_OUT:     out_q  <= wr_bits;
            OFS_DIR:     dir_q  <= wr_bits;
            OFS_OE:      oe_q   <= wr_bits;
            OFS_IUNMASK: mask_q <= mask_q & ~wr_bits;
            OFS_IMASKON: mask_q <= mask_q | wr_bits;
            OFS_ITYPE:   type_q <= wr_bits;
            OFS_IPOL:    pol_q  <= wr_bits;
            OFS_IANY:    any_q  <= wr_bits;
            default:     ;
         endcase
      end
   end

   always_comb begin
      rdata = '0;
      case (ofs)
         OFS_OUT_LO: rdata[HALF-1:0]  = out_q[HALF-1:0];
         OFS_OUT_HI: rdata[HALF-1:0]  = out_q[PIN_W-1:HALF];
         OFS_OUT:    rdata[PIN_W-1:0] = out_q;
         OFS_IN:     rdata[PIN_W-1:0] = lvl;
         OFS_DIR:    rdata[PIN_W-1:0] = dir_q;
         OFS_OE:     rdata[PIN_W-1:0] = oe_q;
         OFS_IMASK:  rdata[PIN_W-1:0] = mask_q;
         OFS_ISTAT:  rdata[PIN_W-1:0] = stat;
         OFS_ITYPE:  rdata[PIN_W-1:0] = type_q;
         OFS_IPOL:   rdata[PIN_W-1:0] = pol_q;
         OFS_IANY:   rdata[PIN_W-1:0] = any_q;
         default:    rdata = '0;
      endcase
   end

   assign pin_o  = out_q;
   assign pin_oe = dir_q & oe_q;
   assign irq_o  = |(stat & ~mask_q);

   // R2: protected bits of the lower half keep their old value
   p_mask_keep_r2: assert property (@(posedge clk) disable iff (rst)
      $past(wr_en && ofs == OFS_OUT_LO) |->
         (((out_q[HALF-1:0] ^ $past(out_q[HALF-1:0])) & $past(wr_mask)) == '0));

   // R5: drive enables move only after a register write
   p_oe_hold_r5: assert property (@(posedge clk) disable iff (rst)
      !$past(wr_en) |-> $stable(pin_oe));

   // R7: an unmask write leaves every written-one pin unmasked
   p_unmask_r7: assert property (@(posedge clk) disable iff (rst)
      $past(wr_en && ofs == OFS_IUNMASK) |-> ((mask_q & $past(wr_bits)) == '0));

   // R7: a mask write leaves every written-one pin masked
   p_maskon_r7: assert property (@(posedge clk) disable iff (rst)
      $past(wr_en && ofs == OFS_IMASKON) |-> ((~mask_q & $past(wr_bits)) == '0));
endmodule

// File: rtl/gpio_banked.sv
module gpio_banked
   import gpio_pkg::*;
#(
   parameter int  NUM_BANKS   = 2,
   parameter int  PIN_W       = 32,
   parameter int  SYNC_STAGES = 2,
   localparam int BANK_BITS   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int ADDR_W      = BANK_BITS + OFS_W,
   localparam int ALL_W       = NUM_BANKS * PIN_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic [ALL_W-1:0]  pin_in,
   output logic [ALL_W-1:0]  pin_out,
   output logic [ALL_W-1:0]  pin_oe,
   output logic              irq
);
   if (NUM_BANKS < 1) begin : g_bad_banks
      $error("gpio_banked: NUM_BANKS must be at least 1");
   end
   if ((PIN_W % 2) != 0 || PIN_W > BUS_W || PIN_W / 2 > BUS_W - MASK_LSB) begin : g_bad_width
      $error("gpio_banked: PIN_W must be even and fit the half-word mask layout");
   end

   logic [BANK_BITS-1:0] bank_idx;
   reg_ofs_e             ofs;
   logic [BUS_W-1:0]     rd_all [NUM_BANKS];
   logic [NUM_BANKS-1:0] bank_irq;

   assign bank_idx = bus_addr[ADDR_W-1:OFS_W];
   assign ofs      = reg_ofs_e'(bus_addr[OFS_W-1:0]);

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic sel;
      assign sel = (int'(bank_idx) == b);

      gpio_bank #(.PIN_W(PIN_W), .SYNC_STAGES(SYNC_STAGES)) u_bank (
         .clk    (clk),
         .rst    (rst),
         .wr_en  (bus_wr && sel),
         .ofs    (ofs),
         .wdata  (bus_wdata),
         .rdata  (rd_all[b]),
         .pin_i  (pin_in[b*PIN_W +: PIN_W]),
         .pin_o  (pin_out[b*PIN_W +: PIN_W]),
         .pin_oe (pin_oe[b*PIN_W +: PIN_W]),
         .irq_o  (bank_irq[b])
      );
   end

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NUM_BANKS; i++) begin
         if (int'(bank_idx) == i) bus_rdata = rd_all[i];
      end
   end

   assign irq = |bank_irq;
endmodule

// File: tb/gpio_banked_tb.sv
`timescale 1ns/100ps
module gpio_banked_tb;
   localparam int NB = 2;
   localparam int PW = 32;

   typedef struct {
      int          kind;   // 0 rdata, 1 pin_oe, 2 pin_out, 3 irq
      int          bank;
      logic [31:0] exp;
      string       req;
   } item_t;

   logic            clk = 0;
   logic            rst = 1;
   logic            bus_wr = 0;
   logic [4:0]      bus_addr = '0;
   logic [31:0]     bus_wdata = '0;
   logic [31:0]     bus_rdata;
   logic [NB*PW-1:0] pin_in = '0;
   logic [NB*PW-1:0] pin_out, pin_oe;
   logic            irq;

   int total = 0;
   int bad   = 0;
   bit done  = 0;
   item_t sb_q[$];

   always #2.5 clk = ~clk;

   gpio_banked #(.NUM_BANKS(NB), .PIN_W(PW)) u_dut (
      .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
   );

   // monitor: compares on the falling edge of the cycle the item was issued
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         item_t it;
         logic [31:0] act;
         it = sb_q.pop_front();
         case (it.kind)
            0: act = bus_rdata;
            1: act = pin_oe[it.bank*PW +: PW];
            2: act = pin_out[it.bank*PW +: PW];
            default: act = {31'b0, irq};
         endcase
         total++;
         if (act !== it.exp) begin
            bad++;
            $display("FAIL %s: actual=%08h expected=%08h", it.req, act, it.exp);
         end
      end
   end

   function automatic logic [4:0] ra(int bank, int ofs);
      return 5'(bank * 16 + ofs);
   endfunction

   task automatic wr(int bank, int ofs, logic [31:0] d);
      @(posedge clk); #1;
      bus_wr = 1; bus_addr = ra(bank, ofs); bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 0;
   endtask

   task automatic push(int kind, int bank, int ofs, logic [31:0] e, string req);
      item_t it;
      @(posedge clk); #1;
      bus_addr = ra(bank, ofs);
      it.kind = kind; it.bank = bank; it.exp = e; it.req = req;
      sb_q.push_back(it);
   endtask

   task automatic rd(int bank, int ofs, logic [31:0] e, string req);
      push(0, bank, ofs, e, req);
   endtask

   task automatic set_pins(int bank, logic [31:0] v);
      @(posedge clk); #1;
      pin_in[bank*PW +: PW] = v;
   endtask

   task automatic idle(int n);
      repeat (n) @(posedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      idle(3); #1; rst = 0;

      // R1 reset state
      rd(0, 2, 32'h0, "R1 out reg");
      rd(0, 6, 32'hFFFF_FFFF, "R1 mask all set");
      rd(1, 6, 32'hFFFF_FFFF, "R1 bank1 mask");
      push(1, 0, 0, 32'h0, "R1 pin_oe");
      push(3, 0, 0, 32'h0, "R1 irq");

      // R4 full write
      wr(0, 2, 32'h1234_5678);
      rd(0, 2, 32'h1234_5678, "R4 readback");
      push(2, 0, 2, 32'h1234_5678, "R4 pin_out");

      // R2 / R3 masked halves
      wr(0, 0, {16'hFF00, 16'hABCD});
      rd(0, 0, 32'h0000_56CD, "R3 lower half read");
      wr(0, 1, {16'h0F0F, 16'hFFFF});
      rd(0, 1, 32'h0000_F2F4, "R3 upper half read");
      rd(0, 2, 32'hF2F4_56CD, "R2 masked update");
      wr(0, 0, {16'hFFFF, 16'h0000});
      rd(0, 2, 32'hF2F4_56CD, "R2 full mask keeps all");

      // R5 output enable gating
      wr(0, 4, 32'h0000_FFFF);
      push(1, 0, 0, 32'h0, "R5 dir only");
      wr(0, 5, 32'h00FF_00FF);
      push(1, 0, 0, 32'h0000_00FF, "R5 dir and oe");

      // R12 bank isolation
      wr(1, 2, 32'hCAFE_F00D);
      rd(1, 2, 32'hCAFE_F00D, "R12 bank1 out");
      rd(0, 2, 32'hF2F4_56CD, "R12 bank0 untouched");
      push(2, 1, 2, 32'hCAFE_F00D, "R12 bank1 pins");
      push(1, 1, 0, 32'h0, "R12 bank1 oe");

      // R6 input synchroniser latency
      set_pins(0, 32'h0000_0081);
      rd(0, 3, 32'h0, "R6 old level after one edge");
      rd(0, 3, 32'h0000_0081, "R6 new level after two edges");
      wr(0, 3, 32'hFFFF_FFFF);
      rd(0, 3, 32'h0000_0081, "R6 write ignored");
      set_pins(0, 32'h0);
      idle(4);

      // interrupt setup: bits 0-3 edge, bit 4 level high
      wr(0, 10, 32'h0000_000F);
      wr(0, 11, 32'h0000_0015);
      wr(0, 12, 32'h0000_0008);
      idle(3);
      wr(0, 9, 32'h0000_000F);
      rd(0, 9, 32'hFFFF_FFE0, "R10 level status idle");

      // R8 edge detection with latency
      set_pins(0, 32'h0000_001F);
      idle(1);
      rd(0, 9, 32'hFFFF_FFE0, "R8 status not yet set");
      rd(0, 9, 32'hFFFF_FFFD, "R8 rising and any-edge set");
      set_pins(0, 32'h0);
      idle(4);
      rd(0, 9, 32'hFFFF_FFEF, "R8 falling set, R10 level cleared");

      // R9 / R10 clear behaviour
      wr(0, 9, 32'h0);
      rd(0, 9, 32'hFFFF_FFEF, "R9 zero write no effect");
      wr(0, 9, 32'hFFFF_0005);
      rd(0, 9, 32'hFFFF_FFEA, "R9 w1c edge, R10 level kept");

      // R7 / R11 mask control and interrupt
      push(3, 0, 0, 32'h0, "R11 all masked");
      wr(0, 7, 32'h0000_0002);
      rd(0, 6, 32'hFFFF_FFFD, "R7 unmask bit1");
      push(3, 0, 0, 32'h1, "R11 unmasked status");
      wr(0, 7, 32'h0);
      rd(0, 6, 32'hFFFF_FFFD, "R7 zero unmask no effect");
      wr(0, 8, 32'h0000_0002);
      rd(0, 6, 32'hFFFF_FFFF, "R7 mask again");
      push(3, 0, 0, 32'h0, "R11 masked again");
      wr(0, 7, 32'h0000_0002);
      wr(0, 9, 32'h0000_0002);
      push(3, 0, 0, 32'h0, "R9 cleared status drops irq");

      // R10 level interrupt with latency
      wr(0, 7, 32'h0000_0010);
      push(3, 0, 0, 32'h0, "R10 level low no irq");
      set_pins(0, 32'h0000_0010);
      idle(1);
      push(3, 0, 0, 32'h0, "R10 irq not yet");
      push(3, 0, 0, 32'h1, "R10 level irq");
      set_pins(0, 32'h0);
      idle(4);
      push(3, 0, 0, 32'h0, "R10 level irq follows input");

      // R11 across banks
      wr(1, 7, 32'h0000_0001);
      push(3, 1, 0, 32'h1, "R11 bank1 contributes");
      wr(1, 8, 32'h0000_0001);
      push(3, 1, 0, 32'h0, "R11 bank1 masked");

      idle(2);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule